// File: doc/BRIEF.md
# Synchronized Dual-Rate Interval Timers

This block turns one free-running external timer tick of nominally 100 kHz into two interval counts kept in the machine-cycle clock domain. The tick input is asynchronous. It passes through a synchronizer chain, and its falling edge is turned into a pulse one system clock wide. Because every later decision is made in the system clock domain, start, stop, load and read requests act coherently within one machine cycle.

Timer A advances on every synchronized tick, which gives a 10 µs resolution. A free-running divide-by-ten prescaler, which only reset clears, fires once in every ten synchronized ticks and advances timer B, which gives a 100 µs resolution. Each timer has its own control state machine with two named states, `T_HALTED` and `T_COUNTING`:
- a start request takes `T_HALTED` to `T_COUNTING`;
- a stop request takes `T_COUNTING` to `T_HALTED`;
- with no request, the state is held.

When a timer wraps from all ones to zero, it raises a sticky overflow flag and a one-cycle interrupt pulse.

Top module: `dual_rate_interval_timer`

## Requirements
- R1: After reset, both counts read 0, both overflow flags and both interrupts are 0, and both timers are in `T_HALTED`.
- R2: Only a falling edge of `tick_async` produces a synchronized tick. A rising edge changes no count. Each falling edge, with the input held at least two clocks on each level, produces exactly one tick.
- R3: While in `T_COUNTING`, timer A's count increases by exactly one per synchronized tick.
- R4: The prescaler counts every synchronized tick from reset onward, whether either timer is running or not. On every tenth tick it advances timer B if timer B is counting. A timer load or stop does not clear the prescaler.
- R5: In `T_HALTED`, a timer ignores ticks and its count stays unchanged and readable on its output.
- R6: A load request writes the load value into the count in the next cycle, in either state, without changing the state. A load takes priority over a tick in the same cycle; that tick is lost for that timer.
- R7: A start and a stop request in the same cycle leave or put the timer in `T_HALTED`, because stop has priority.
- R8: A counting tick at count 0xFFFF yields count 0 and a single-cycle pulse on that timer's interrupt output.
- R9: A timer's overflow flag is set by its first wrap and stays set until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Machine-cycle system clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_async | input | 1 | External 100 kHz timer tick, asynchronous |
| a_load | input | 1 | Timer A load request |
| a_load_val | input | 16 | Value written by a timer A load |
| a_start | input | 1 | Timer A start request |
| a_stop | input | 1 | Timer A stop request |
| b_load | input | 1 | Timer B load request |
| b_load_val | input | 16 | Value written by a timer B load |
| b_start | input | 1 | Timer B start request |
| b_stop | input | 1 | Timer B stop request |
| a_count | output | 16 | Timer A current count |
| b_count | output | 16 | Timer B current count |
| a_ovf_flag | output | 1 | Timer A sticky overflow flag |
| b_ovf_flag | output | 1 | Timer B sticky overflow flag |
| a_irq | output | 1 | Timer A one-cycle wrap interrupt |
| b_irq | output | 1 | Timer B one-cycle wrap interrupt |

## Verification
The assertions take for granted that the tick input holds each level for at least two system clocks. This gap is what makes synchronized ticks, and so timer A's interrupt pulses, never fall on adjacent cycles. The stimulus keeps each level for four clocks. Requests are single-cycle pulses driven one time unit after a rising edge. The one exception is the load-priority case, where a load is held across a whole tick on purpose.

// File: rtl/drt_pkg.sv
package drt_pkg;

    typedef enum logic {
        T_HALTED   = 1'b0,
        T_COUNTING = 1'b1
    } timer_state_e;

    localparam int DEF_CNT_W       = 16;
    localparam int DEF_PRESCALE    = 10;
    localparam int DEF_SYNC_STAGES = 2;

endpackage

// File: rtl/drt_tick_sync.sv
module drt_tick_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick_async,
    output logic tick_pulse
);
    // chain[STAGES-1] is the synchronized level; chain[STAGES] is its history.
    logic [STAGES:0] chain;

    always_ff @(posedge clk) begin
        if (!rst_n) chain[0] <= 1'b0;
        else        chain[0] <= tick_async;
    end

    generate
        for (genvar i = 1; i <= STAGES; i++) begin : g_stage
            always_ff @(posedge clk) begin
                if (!rst_n) chain[i] <= 1'b0;
                else        chain[i] <= chain[i-1];
            end
        end
    endgenerate

    // Falling edge of the synchronized level: it was high and is now low.
    assign tick_pulse = chain[STAGES] & ~chain[STAGES-1];

    // R2: with each input level held two clocks or more, the pulse never repeats on adjacent cycles
    a_r2_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        tick_pulse |=> !tick_pulse);

endmodule

// File: rtl/drt_prescaler.sv
module drt_prescaler #(
    parameter int DIV = 10
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick_in,
    output logic tick_out
);
    localparam int PW = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [PW-1:0] LAST = PW'(DIV - 1);

    logic [PW-1:0] phase;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase <= '0;
        end else if (tick_in) begin
            if (phase == LAST) phase <= '0;
            else               phase <= phase + PW'(1);
        end
    end

    assign tick_out = tick_in && (phase == LAST);

    // R4: the phase never leaves its range
    a_r4_phase_range: assert property (@(posedge clk) disable iff (!rst_n)
        phase <= LAST);

    // R4: with no tick the phase holds
    a_r4_phase_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !tick_in |=> $stable(phase));

endmodule

// File: rtl/drt_interval_timer.sv
module drt_interval_timer
    import drt_pkg::*;
#(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         step,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         start,
    input  logic         stop,
    output logic [W-1:0] count,
    output logic         ovf_flag,
    output logic         irq
);
    timer_state_e state, state_nxt;
    logic         wrap;

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= T_HALTED;
        else        state <= state_nxt;
    end

    // Transitions: stop outranks start
    always_comb begin
        state_nxt = state;
        unique case (state)
            T_HALTED:   if (start && !stop) state_nxt = T_COUNTING;
            T_COUNTING: if (stop)           state_nxt = T_HALTED;
            default:                        state_nxt = T_HALTED;
        endcase
    end

    assign wrap = (state == T_COUNTING) && step && !load && (count == '1);

    // Outputs: count, sticky flag, interrupt pulse
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count    <= '0;
            ovf_flag <= 1'b0;
            irq      <= 1'b0;
        end else begin
            if (load)
                count <= load_val;
            else if ((state == T_COUNTING) && step)
                count <= count + W'(1);
            irq      <= wrap;
            ovf_flag <= ovf_flag | wrap;
        end
    end

    // R3: a counting tick without load advances by one
    a_r3_step: assert property (@(posedge clk) disable iff (!rst_n)
        (state == T_COUNTING && step && !load) |=> count == $past(count) + W'(1));

    // R5: halted and not loaded holds the count
    a_r5_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (state == T_HALTED && !load) |=> $stable(count));

    // R6: load wins over everything
    a_r6_load: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> count == $past(load_val));

    // R7: stop always lands in T_HALTED
    a_r7_stop_wins: assert property (@(posedge clk) disable iff (!rst_n)
        stop |=> state == T_HALTED);

    // R8: interrupt coincides with a zero count and a set flag
    a_r8_irq_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (count == '0) && ovf_flag);

    // R9: flag is sticky
    a_r9_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_flag |=> ovf_flag);

endmodule

// File: rtl/dual_rate_interval_timer.sv
module dual_rate_interval_timer
    import drt_pkg::*;
#(
    parameter int CNT_W       = DEF_CNT_W,
    parameter int PRESCALE    = DEF_PRESCALE,
    parameter int SYNC_STAGES = DEF_SYNC_STAGES
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_async,
    input  logic             a_load,
    input  logic [CNT_W-1:0] a_load_val,
    input  logic             a_start,
    input  logic             a_stop,
    input  logic             b_load,
    input  logic [CNT_W-1:0] b_load_val,
    input  logic             b_start,
    input  logic             b_stop,
    output logic [CNT_W-1:0] a_count,
    output logic [CNT_W-1:0] b_count,
    output logic             a_ovf_flag,
    output logic             b_ovf_flag,
    output logic             a_irq,
    output logic             b_irq
);
    logic fine_tick;
    logic coarse_tick;

    drt_tick_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick_async (tick_async),
        .tick_pulse (fine_tick)
    );

    drt_prescaler #(.DIV(PRESCALE)) u_pre (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick_in  (fine_tick),
        .tick_out (coarse_tick)
    );

    drt_interval_timer #(.W(CNT_W)) u_tmr_a (
        .clk      (clk),
        .rst_n    (rst_n),
        .step     (fine_tick),
        .load     (a_load),
        .load_val (a_load_val),
        .start    (a_start),
        .stop     (a_stop),
        .count    (a_count),
        .ovf_flag (a_ovf_flag),
        .irq      (a_irq)
    );

    drt_interval_timer #(.W(CNT_W)) u_tmr_b (
        .clk      (clk),
        .rst_n    (rst_n),
        .step     (coarse_tick),
        .load     (b_load),
        .load_val (b_load_val),
        .start    (b_start),
        .stop     (b_stop),
        .count    (b_count),
        .ovf_flag (b_ovf_flag),
        .irq      (b_irq)
    );

    // R4: the coarse tick only ever accompanies a fine tick
    a_r4_coarse_subset: assert property (@(posedge clk) disable iff (!rst_n)
        coarse_tick |-> fine_tick);

endmodule

// File: tb/dual_rate_interval_timer_bench.sv
module dual_rate_interval_timer_bench;

    localparam int W = 16;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         tick_async = 1'b0;
    logic         a_load = 1'b0, a_start = 1'b0, a_stop = 1'b0;
    logic         b_load = 1'b0, b_start = 1'b0, b_stop = 1'b0;
    logic [W-1:0] a_load_val = '0, b_load_val = '0;
    logic [W-1:0] a_count, b_count;
    logic         a_ovf_flag, b_ovf_flag, a_irq, b_irq;

    always #5 clk = ~clk;

    dual_rate_interval_timer u_dual_rate_interval_timer (
        .clk(clk), .rst_n(rst_n), .tick_async(tick_async),
        .a_load(a_load), .a_load_val(a_load_val), .a_start(a_start), .a_stop(a_stop),
        .b_load(b_load), .b_load_val(b_load_val), .b_start(b_start), .b_stop(b_stop),
        .a_count(a_count), .b_count(b_count),
        .a_ovf_flag(a_ovf_flag), .b_ovf_flag(b_ovf_flag),
        .a_irq(a_irq), .b_irq(b_irq)
    );

    typedef struct {
        string        req;
        logic [W-1:0] a, b;
        logic         fa, fb;
        int           ia, ib;
    } exp_t;

    exp_t q[$];
    int   compared = 0, mismatched = 0;
    int   irq_a_seen = 0, irq_b_seen = 0;
    bit   done = 1'b0;

    // Reference model state
    logic [W-1:0] m_a = '0, m_b = '0;
    logic         m_fa = 1'b0, m_fb = 1'b0;
    logic         m_run_a = 1'b0, m_run_b = 1'b0;
    int           m_pre = 0, m_ia = 0, m_ib = 0;

    task automatic check_one(string req, string what, int act, int exp);
        compared++;
        if (act != exp) begin
            mismatched++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // Monitor: pops expectations and compares to the ports
    always @(negedge clk) begin
        if (rst_n && a_irq) irq_a_seen++;
        if (rst_n && b_irq) irq_b_seen++;
        while (q.size() > 0) begin
            exp_t e;
            e = q.pop_front();
            check_one(e.req, "a_count", int'(a_count), int'(e.a));
            check_one(e.req, "b_count", int'(b_count), int'(e.b));
            check_one(e.req, "a_ovf_flag", int'(a_ovf_flag), int'(e.fa));
            check_one(e.req, "b_ovf_flag", int'(b_ovf_flag), int'(e.fb));
            check_one(e.req, "a_irq pulses", irq_a_seen, e.ia);
            check_one(e.req, "b_irq pulses", irq_b_seen, e.ib);
        end
    end

    task automatic push(string req);
        exp_t e;
        e.req = req; e.a = m_a; e.b = m_b; e.fa = m_fa; e.fb = m_fb;
        e.ia = m_ia; e.ib = m_ib;
        q.push_back(e);
        @(negedge clk);
        @(negedge clk);
    endtask

    task automatic cycles(int n);
        for (int i = 0; i < n; i++) @(posedge clk);
        #1;
    endtask

    // Model of one synchronized tick; load_a_held means timer A is being loaded
    task automatic model_tick(bit load_a_held);
        if (m_run_a && !load_a_held) begin
            if (m_a == '1) begin m_fa = 1'b1; m_ia++; end
            m_a = m_a + W'(1);
        end
        if (m_pre == 9) begin
            m_pre = 0;
            if (m_run_b) begin
                if (m_b == '1) begin m_fb = 1'b1; m_ib++; end
                m_b = m_b + W'(1);
            end
        end else begin
            m_pre++;
        end
    endtask

    task automatic do_tick();
        @(posedge clk); #1 tick_async = 1'b1;
        cycles(4);
        tick_async = 1'b0;
        cycles(5);
        model_tick(1'b0);
    endtask

    task automatic ticks(int n);
        for (int i = 0; i < n; i++) do_tick();
    endtask

    task automatic pulse_a(bit ld, logic [W-1:0] v, bit st, bit sp);
        @(posedge clk); #1;
        a_load = ld; a_load_val = v; a_start = st; a_stop = sp;
        @(posedge clk); #1;
        a_load = 1'b0; a_start = 1'b0; a_stop = 1'b0;
        if (ld) m_a = v;
        if (sp) m_run_a = 1'b0; else if (st) m_run_a = 1'b1;
    endtask

    task automatic pulse_b(bit ld, logic [W-1:0] v, bit st, bit sp);
        @(posedge clk); #1;
        b_load = ld; b_load_val = v; b_start = st; b_stop = sp;
        @(posedge clk); #1;
        b_load = 1'b0; b_start = 1'b0; b_stop = 1'b0;
        if (ld) m_b = v;
        if (sp) m_run_b = 1'b0; else if (st) m_run_b = 1'b1;
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!done) begin
            mismatched++;
            compared++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end

    initial begin : driver
        cycles(3);
        rst_n = 1'b1;
        cycles(1);
        push("R1 reset");

        ticks(1);                      // halted timers ignore the tick; prescaler counts
        push("R5 halted ignores tick");

        pulse_a(1'b0, '0, 1'b1, 1'b0);
        ticks(3);
        push("R3 timer A counts ticks");

        pulse_b(1'b0, '0, 1'b1, 1'b0);
        ticks(6);                      // tenth tick since reset advances B
        push("R4 timer B on tenth tick");

        ticks(5);
        pulse_b(1'b1, 16'd100, 1'b0, 1'b0);
        ticks(5);                      // prescaler phase survives the load
        push("R4 prescaler not cleared by load");

        pulse_a(1'b0, '0, 1'b0, 1'b1);
        ticks(3);
        push("R5 stopped A keeps count");

        pulse_a(1'b0, '0, 1'b1, 1'b1);
        ticks(1);
        push("R7 stop beats start");

        pulse_a(1'b1, 16'hFFFE, 1'b1, 1'b0);
        push("R6 load value visible");
        ticks(2);
        push("R8 timer A wrap and irq");

        ticks(2);
        push("R9 flag A stays set");

        pulse_b(1'b1, 16'hFFFF, 1'b0, 1'b0);
        ticks(2);                      // second tick is tenth of its group
        push("R8 timer B wrap and irq");

        // R6: load held across a whole tick beats the tick
        @(posedge clk); #1;
        a_load = 1'b1; a_load_val = 16'h0050;
        tick_async = 1'b1;
        cycles(4);
        tick_async = 1'b0;
        cycles(5);
        a_load = 1'b0;
        m_a = 16'h0050;
        model_tick(1'b1);
        push("R6 load beats tick");

        // R2: a rising edge alone changes nothing
        @(posedge clk); #1 tick_async = 1'b1;
        cycles(8);
        push("R2 rising edge no tick");
        tick_async = 1'b0;
        cycles(5);
        model_tick(1'b0);
        push("R2 falling edge one tick");

        cycles(4);
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

endmodule